// File: doc/BRIEF.md
# Windowed Framing Code Detector

This block sits behind an external data slicer that delivers a serial bit stream together with its bit clock. A line sync input marks the start of each video line. On the active sync edge the block starts a phase count in bit clocks. After a programmed delay it opens a search window that is 16 bit clocks wide. Inside that window it looks for an 8-bit framing code that the host has loaded. The window is also driven onto an output pin, so that the host or a scope can see where the search takes place.

Once the code is found, the block groups the bits that follow into bytes. It hands them downstream on a valid/ready byte stream until the byte count set downstream has been produced. A new line sync also ends byte output. The serial stream cannot be paused, so back-pressure is absorbed by a single holding slot. A byte that completes while the slot is still occupied and not being accepted is lost. Clock recovery, error correction and storage live elsewhere.

Top module: `frame_window_detector`

## Requirements
- R1: The active sync event is a transition of `sync_in` to the level given by `sync_pol` (1: a rising edge, 0: a falling edge). A transition to the other level has no effect, and a steady level does not retrigger.
- R2: If the active sync transition is sampled at clock edge n, `win_o` is high after edges n+`win_delay` through n+`win_delay`+15 inclusive, which is exactly 16 cycles, and low otherwise. `win_delay` may be anywhere from 0 to 127.
- R3: Serial bits are taken LSB first, one per clock. A match occurs when the 8 most recent bits, the oldest in bit 0 and the newest in bit 7, equal `frame_code`, and the newest bit is sampled in a cycle where `win_o` is high. Earlier bits of the code may arrive before the window opens.
- R4: At most one match is accepted per line. After the match, further occurrences of the code in the stream, even inside the window, start nothing new.
- R5: The bits after the match form bytes, LSB first, with the first bit after the code in bit 0. Exactly `byte_len` bytes are produced per matched line. When `byte_len` is 0, no bytes are produced.
- R6: When the window closes without a match, no byte is produced for that line.
- R7: An active sync transition during byte assembly stops output at once, discards the partial byte and restarts the window timing from that transition.
- R8: `m_valid` with `m_data` stays set and unchanged until `m_ready` is seen high. A byte that completes in a cycle where the slot holds an unaccepted byte and `m_ready` is low is dropped.
- R9: After reset, `win_o` and `m_valid` are low, and no window opens before the first active sync transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data bit clock from the slicer |
| rst_n | input | 1 | Active-low synchronous reset |
| sd_in | input | 1 | Serial data bit, sampled each clock |
| sync_in | input | 1 | Line sync from the slicer |
| sync_pol | input | 1 | Active sync level: 1 rising, 0 falling |
| frame_code | input | 8 | Framing code to search for |
| win_delay | input | 7 | Bit clocks from sync to window opening |
| byte_len | input | 6 | Bytes to emit after a match |
| win_o | output | 1 | High during the search window |
| m_valid | output | 1 | Byte stream valid |
| m_ready | input | 1 | Byte stream ready |
| m_data | output | 8 | Byte stream data |

## Verification
A wrong phase count appears on `win_o` in the first cycle of the misplaced window. It also shifts which code positions match, so a missed or extra match shows up on `m_valid` about eight cycles later. A bad bit or byte count, or a state that fails to leave the hunt, shows as a wrong number of bytes or as wrongly aligned byte values within a byte time of the fault. Slot errors show on `m_valid` and `m_data` in the very next cycle under back-pressure. The bench compares every output on every cycle against a behavioural model, so each of these faults is reported in the cycle it first reaches a port.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int CODE_W_DEF  = 8;
  localparam int DELAY_W_DEF = 7;
  localparam int WIN_LEN_DEF = 16;
  localparam int LEN_W_DEF   = 6;

  typedef enum logic [1:0] {
    DS_IDLE  = 2'd0,
    DS_SEEK  = 2'd1,
    DS_BYTES = 2'd2
  } ds_state_e;
endpackage

// File: rtl/fwd_sync_edge.sv
module fwd_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  input  logic pol,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_in;
  end

  assign edge_o = (sync_in != prev_q) && (sync_in == pol);

  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o); // R1
endmodule

// File: rtl/fwd_window_timer.sv
module fwd_window_timer #(
  parameter int DELAY_W = 7,
  parameter int WIN_LEN = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_start,
  input  logic [DELAY_W-1:0] delay,
  output logic               win_o
);
  localparam int PH_MAX = (1 << DELAY_W) - 1 + WIN_LEN;
  localparam int PH_W   = $clog2(PH_MAX + 1);

  logic            armed_q;
  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] open_at;
  logic [PH_W-1:0] close_at;

  assign open_at  = {{(PH_W-DELAY_W){1'b0}}, delay};
  assign close_at = open_at + PH_W'(WIN_LEN - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      phase_q <= '0;
    end else if (line_start) begin
      armed_q <= 1'b1;
      phase_q <= '0;
    end else if (armed_q) begin
      if (phase_q >= close_at) armed_q <= 1'b0;
      else                     phase_q <= phase_q + 1'b1;
    end
  end

  assign win_o = armed_q && (phase_q >= open_at);

  localparam int RUN_W = $clog2(WIN_LEN + 2);
  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk) begin
    if (!rst_n || line_start) run_q <= '0;
    else if (win_o)           run_q <= run_q + 1'b1;
  end

  AST_WIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    win_o |-> (run_q < RUN_W'(WIN_LEN))); // R2
endmodule

// File: rtl/fwd_deser.sv
module fwd_deser #(
  parameter int CODE_W = 8,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              win,
  input  logic              sd,
  input  logic [CODE_W-1:0] code,
  input  logic [LEN_W-1:0]  len,
  output logic              byte_vld,
  output logic [CODE_W-1:0] byte_data
);
  import fwd_pkg::*;

  localparam int BC_W = $clog2(CODE_W);

  ds_state_e         state_q;
  logic [CODE_W-1:0] shreg_q;
  logic [CODE_W-1:0] cand;
  logic [BC_W-1:0]   bitcnt_q;
  logic [LEN_W-1:0]  bcnt_q;
  logic              hit;
  logic              last_bit;

  assign cand      = {sd, shreg_q[CODE_W-1:1]};
  assign hit       = (state_q == DS_SEEK) && win && (cand == code) && !line_start;
  assign last_bit  = (state_q == DS_BYTES) && (bitcnt_q == BC_W'(CODE_W-1)) && !line_start;
  assign byte_vld  = last_bit;
  assign byte_data = cand;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg_q  <= '0;
      state_q  <= DS_IDLE;
      bitcnt_q <= '0;
      bcnt_q   <= '0;
    end else begin
      shreg_q <= cand;
      if (line_start) begin
        state_q  <= DS_SEEK;
        bitcnt_q <= '0;
        bcnt_q   <= '0;
      end else begin
        case (state_q)
          DS_SEEK: if (hit) begin
            bitcnt_q <= '0;
            bcnt_q   <= '0;
            state_q  <= (len == '0) ? DS_IDLE : DS_BYTES;
          end
          DS_BYTES: begin
            if (last_bit) begin
              bitcnt_q <= '0;
              bcnt_q   <= bcnt_q + 1'b1;
              if ((bcnt_q + 1'b1) == len) state_q <= DS_IDLE;
            end else begin
              bitcnt_q <= bitcnt_q + 1'b1;
            end
          end
          default: state_q <= DS_IDLE;
        endcase
      end
    end
  end

  AST_MATCH_IN_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == DS_BYTES) && ($past(state_q) == DS_SEEK) |-> $past(win)); // R3

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != DS_SEEK) && !line_start |=> (state_q != DS_SEEK)); // R4

  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == DS_BYTES) |-> (bcnt_q < len)); // R5
endmodule

// File: rtl/fwd_out_slot.sv
module fwd_out_slot #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic              vld_q;
  logic [DATA_W-1:0] data_q;
  logic              take;

  assign take = in_vld && (!vld_q || out_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else if (take) begin
      vld_q  <= 1'b1;
      data_q <= in_data;
    end else if (out_ready) begin
      vld_q  <= 1'b0;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = data_q;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R8
endmodule

// File: rtl/frame_window_detector.sv
module frame_window_detector #(
  parameter int CODE_W  = fwd_pkg::CODE_W_DEF,
  parameter int DELAY_W = fwd_pkg::DELAY_W_DEF,
  parameter int WIN_LEN = fwd_pkg::WIN_LEN_DEF,
  parameter int LEN_W   = fwd_pkg::LEN_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sd_in,
  input  logic              sync_in,
  input  logic              sync_pol,
  input  logic [CODE_W-1:0] frame_code,
  input  logic [DELAY_W-1:0] win_delay,
  input  logic [LEN_W-1:0]  byte_len,
  output logic              win_o,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [CODE_W-1:0] m_data
);
  logic              line_start;
  logic              win;
  logic              byte_vld;
  logic [CODE_W-1:0] byte_data;

  fwd_sync_edge u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync_in(sync_in),
    .pol    (sync_pol),
    .edge_o (line_start)
  );

  fwd_window_timer #(.DELAY_W(DELAY_W), .WIN_LEN(WIN_LEN)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_start(line_start),
    .delay     (win_delay),
    .win_o     (win)
  );

  fwd_deser #(.CODE_W(CODE_W), .LEN_W(LEN_W)) u_deser (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_start(line_start),
    .win       (win),
    .sd        (sd_in),
    .code      (frame_code),
    .len       (byte_len),
    .byte_vld  (byte_vld),
    .byte_data (byte_data)
  );

  fwd_out_slot #(.DATA_W(CODE_W)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (byte_vld),
    .in_data  (byte_data),
    .out_valid(m_valid),
    .out_ready(m_ready),
    .out_data (m_data)
  );

  assign win_o = win;

  AST_NO_BYTE_WITH_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    line_start && !m_valid |=> !m_valid); // R7
endmodule

// File: tb/frame_window_detector_tb.sv
module frame_window_detector_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sd_in = 1'b0;
  logic       sync_in = 1'b0;
  logic       sync_pol = 1'b1;
  logic [7:0] frame_code = 8'hE4;
  logic [6:0] win_delay = 7'd10;
  logic [5:0] byte_len = 6'd3;
  logic       m_ready = 1'b1;
  logic       win_o;
  logic       m_valid;
  logic [7:0] m_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string tag = "R9";

  always #10 clk = ~clk;

  frame_window_detector u_dut (
    .clk(clk), .rst_n(rst_n), .sd_in(sd_in), .sync_in(sync_in),
    .sync_pol(sync_pol), .frame_code(frame_code), .win_delay(win_delay),
    .byte_len(byte_len), .win_o(win_o), .m_valid(m_valid),
    .m_ready(m_ready), .m_data(m_data)
  );

  // behavioural reference model
  bit       md_prev, md_armed, md_hv;
  int       md_phase, md_mode, md_bits, md_bytes;
  bit [7:0] md_sh, md_hd;

  always @(posedge clk) begin
    bit       act, win_now, fin;
    bit [7:0] nxt;
    if (!rst_n) begin
      md_prev = 0; md_armed = 0; md_hv = 0; md_phase = 0;
      md_mode = 0; md_bits = 0; md_bytes = 0; md_sh = 0; md_hd = 0;
    end else begin
      act     = (sync_in != md_prev) && (sync_in == sync_pol);
      win_now = md_armed && (md_phase >= int'(win_delay));
      nxt     = {sd_in, md_sh[7:1]};
      fin     = (md_mode == 2) && (md_bits == 7) && !act;
      if (md_hv && m_ready) md_hv = 0;
      if (fin && !md_hv) begin md_hv = 1; md_hd = nxt; end
      if (act) begin
        md_mode = 1; md_bits = 0; md_bytes = 0;
      end else if (md_mode == 1 && win_now && nxt == frame_code) begin
        md_mode = (byte_len == 0) ? 0 : 2; md_bits = 0; md_bytes = 0;
      end else if (md_mode == 2) begin
        if (md_bits == 7) begin
          md_bits = 0; md_bytes++;
          if (md_bytes == int'(byte_len)) md_mode = 0;
        end else md_bits++;
      end
      if (act) begin md_armed = 1; md_phase = 0; end
      else if (md_armed) begin
        if (md_phase >= int'(win_delay) + 15) md_armed = 0;
        else md_phase++;
      end
      md_sh = nxt; md_prev = sync_in;
    end
  end

  task automatic compare();
    bit ew;
    ew = md_armed && (md_phase >= int'(win_delay));
    checks++;
    if (win_o !== ew || m_valid !== md_hv || (md_hv && m_data !== md_hd)) begin
      fails++;
      $display("FAIL %s: win=%b vld=%b data=%h expected win=%b vld=%b data=%h",
               tag, win_o, m_valid, m_data, ew, md_hv, md_hd);
    end
  endtask

  task automatic step(input logic b, input logic s);
    @(negedge clk);
    compare();
    sd_in = b; sync_in = s;
  endtask

  function automatic logic idle_lvl();
    return !sync_pol;
  endfunction

  task automatic zeros(input int n);
    for (int i = 0; i < n; i++) step(1'b0, idle_lvl());
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) step(b[i], idle_lvl());
  endtask

  task automatic pulse();
    step(1'b0, sync_pol);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R9: reset state
    checks++;
    if (win_o !== 1'b0 || m_valid !== 1'b0) begin
      fails++;
      $display("FAIL R9: win=%b vld=%b expected 0 0", win_o, m_valid);
    end
    rst_n = 1'b1;
    tag = "R9 idle after reset"; zeros(30);

    // R2 R3 R5: basic line, rising sync
    tag = "R5 basic line";
    pulse(); zeros(10); send_byte(8'hE4);
    send_byte(8'h11); send_byte(8'hA5); send_byte(8'h3C); zeros(30);

    // R6 / R3 window boundaries with delay 20
    win_delay = 7'd20;
    tag = "R6 code before window";
    pulse(); send_byte(8'hE4); zeros(50);
    tag = "R3 last bit at window start";
    pulse(); zeros(13); send_byte(8'hE4); send_byte(8'h96); zeros(40);
    tag = "R6 last bit one before window";
    pulse(); zeros(12); send_byte(8'hE4); send_byte(8'h96); zeros(40);
    tag = "R3 last bit at window end";
    pulse(); zeros(28); send_byte(8'hE4); send_byte(8'h5B); zeros(40);
    tag = "R6 last bit after window";
    pulse(); zeros(29); send_byte(8'hE4); send_byte(8'h5B); zeros(40);

    // R4: code repeats inside the window
    win_delay = 7'd0; byte_len = 6'd1;
    tag = "R4 single match";
    pulse(); send_byte(8'hE4); send_byte(8'hE4); send_byte(8'hE4); zeros(30);

    // R1: falling polarity, inactive rising edge
    sync_pol = 1'b0; byte_len = 6'd2; win_delay = 7'd5;
    tag = "R1 inactive edge";
    step(1'b0, 1'b1); zeros(5); send_byte(8'hE4); send_byte(8'h77); zeros(30);
    tag = "R1 falling edge";
    pulse(); zeros(5); send_byte(8'hE4); send_byte(8'h0F); send_byte(8'hF0); zeros(30);
    sync_pol = 1'b1; step(1'b0, 1'b0); zeros(5);

    // R5: zero length
    byte_len = 6'd0; win_delay = 7'd3;
    tag = "R5 zero length";
    pulse(); zeros(3); send_byte(8'hE4); send_byte(8'h55); zeros(30);

    // R8: back-pressure
    byte_len = 6'd3; m_ready = 1'b0;
    tag = "R8 back-pressure";
    pulse(); zeros(3); send_byte(8'hE4);
    send_byte(8'hC3); send_byte(8'h81); send_byte(8'h42); zeros(10);
    m_ready = 1'b1; zeros(5);
    m_ready = 1'b0; frame_code = 8'h27;
    pulse(); zeros(3); send_byte(8'h27); send_byte(8'h19); zeros(3);
    m_ready = 1'b1; send_byte(8'h2A); send_byte(8'h3B); zeros(20);

    // R7: sync mid-byte
    byte_len = 6'd4; win_delay = 7'd2;
    tag = "R7 sync aborts bytes";
    pulse(); zeros(2); send_byte(8'h27); send_byte(8'h6E);
    zeros(3); pulse(); zeros(1); send_byte(8'h27); send_byte(8'hD2);
    send_byte(8'h01); send_byte(8'h80); send_byte(8'hFF); zeros(30);

    // R2: delay extremes
    byte_len = 6'd1;
    win_delay = 7'd127;
    tag = "R2 max delay";
    pulse(); zeros(127); send_byte(8'h27); send_byte(8'hBE); zeros(40);
    win_delay = 7'd0;
    tag = "R2 zero delay";
    pulse(); zeros(3); send_byte(8'h27); send_byte(8'hEF); zeros(30);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule